// File: doc/BRIEF.md
# Fractional-Rate Compare Scheduler

This block places successive compare points on a free-running counter so that the average spacing between events is a rational number of timer ticks. The timer clock is written as `quot × freq + rem`, where `freq` is the wanted event rate and `0 <= rem < freq`. Each step usually advances the compare point by `quot` ticks. Sometimes it advances by `quot + 1` ticks. The choice depends on a shortfall accumulator that gains `rem` at every event and gives back `freq` whenever it reaches `freq`. Over `freq` events the compare point therefore moves by exactly the full timer clock count. The long-term rate is exact, even though no single step is fractional.

The counter value comes in from outside. While `run_i` is low the scheduler is idle. On the first enabled cycle it arms: it sets the first compare point to the current count plus `quot_i` and clears the shortfall. After that, each time the counter equals the compare point, the block emits a one-cycle event pulse, toggles a square-wave output and schedules the next point. Working out the quotient and the remainder is left to the host.

Top module: `frac_compare_sched`

## Requirements
- R1: While `rst_n` is low, `cmp_o`, `evt_o` and `wave_o` are all 0.
- R2: On a cycle where `run_i` is 1 and the block is idle, the block arms. In the next cycle `cmp_o` equals (`cnt_i` + `quot_i`) mod 2^16, and the shortfall is 0.
- R3: While `run_i` is 0 the block goes idle. No event occurs, and `wave_o` and `cmp_o` hold their values.
- R4: When the block is armed and `run_i` is 1 and `cnt_i` equals `cmp_o` in a cycle, `evt_o` is 1 in the next cycle only. It is 0 at all other times.
- R5: `wave_o` inverts in exactly the cycles where `evt_o` is 1, and stays unchanged otherwise.
- R6: At each event, `rem_i` is added to the shortfall. If the sum is at least `freq_i`, `cmp_o` advances by `quot_i` + 1 and the new shortfall is the sum minus `freq_i`. Otherwise `cmp_o` advances by `quot_i` and the new shortfall is the sum.
- R7: Every compare-point addition wraps modulo 2^16, the range of the counter.
- R8: With `rem_i < freq_i`, after `freq_i` events counted from arming, `cmp_o` has moved by exactly `quot_i × freq_i + rem_i` (mod 2^16). For example, quot=37, rem=208, freq=880 gives 32768.
- R9: If `run_i` is dropped and raised again, the block re-arms with a cleared shortfall. Any residue left from the previous run does not affect the first step after re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Current value of the free-running counter |
| run_i | input | 1 | Enable; the rising level arms the scheduler |
| quot_i | input | 16 | Integer quotient of timer clock / target rate |
| rem_i | input | 16 | Remainder of that division |
| freq_i | input | 16 | Target rate, used as the shortfall threshold |
| cmp_o | output | 16 | Next compare point |
| evt_o | output | 1 | One-cycle pulse after each compare match |
| wave_o | output | 1 | Square wave toggled on every event |

## Verification
The hardest state to reach from the ports is a nonzero shortfall at the moment the block is re-armed. That is the only case in which failing to clear the accumulator would show up. The stimulus gets there by stopping a run after eight events with quot=3, rem=5 and freq=7, which leaves a residue of 5, and then checking that the first step after re-arming is 3 and not 4. The compare-point wrap is reached by loading the counter input with 0xFFF0 just before arming. Exactness over a whole cycle of the accumulator is shown by a run of 880 events with the 37/208/880 setting.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/fcs_match.sv
module fcs_match #(
    parameter int CW = 16
) (
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmp_i,
    output logic          hit_o
);
    always_comb begin
        hit_o = active_i && (cnt_i == cmp_i);
    end
endmodule

// File: rtl/fcs_shortfall.sv
module fcs_shortfall #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] rem_i,
    input  logic [AW-1:0] freq_i,
    output logic [AW-1:0] acc_o,
    output logic          extra_o
);
    localparam int SW = AW + 1;

    logic [SW-1:0] sum;
    logic [SW-1:0] lim;

    always_comb begin
        sum     = {1'b0, acc_i} + {1'b0, rem_i};
        lim     = {1'b0, freq_i};
        extra_o = (sum >= lim);
        if (extra_o) begin
            acc_o = AW'(sum - lim);
        end else begin
            acc_o = sum[AW-1:0];
        end
    end
endmodule

// File: rtl/fcs_advance.sv
module fcs_advance #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] base_i,
    input  logic [CW-1:0] step_i,
    input  logic          extra_i,
    output logic [CW-1:0] sum_o
);
    always_comb begin
        sum_o = base_i + step_i + {{(CW-1){1'b0}}, extra_i};
    end
endmodule

// File: rtl/frac_compare_sched.sv
module frac_compare_sched #(
    parameter int CW = 16,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          run_i,
    input  logic [CW-1:0] quot_i,
    input  logic [AW-1:0] rem_i,
    input  logic [AW-1:0] freq_i,
    output logic [CW-1:0] cmp_o,
    output logic          evt_o,
    output logic          wave_o
);
    import fcs_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cmp;
        logic [AW-1:0] acc;
        logic          evt;
        logic          wave;
    } state_t;

    state_t st_d, st_q;

    logic          hit;
    logic [AW-1:0] acc_nx;
    logic          extra;
    logic [CW-1:0] arm_pt;
    logic [CW-1:0] next_pt;

    fcs_match #(.CW(CW)) u_match (
        .active_i (run_i && (st_q.phase == PH_RUN)),
        .cnt_i    (cnt_i),
        .cmp_i    (st_q.cmp),
        .hit_o    (hit)
    );

    fcs_shortfall #(.AW(AW)) u_short (
        .acc_i   (st_q.acc),
        .rem_i   (rem_i),
        .freq_i  (freq_i),
        .acc_o   (acc_nx),
        .extra_o (extra)
    );

    fcs_advance #(.CW(CW)) u_arm (
        .base_i  (cnt_i),
        .step_i  (quot_i),
        .extra_i (1'b0),
        .sum_o   (arm_pt)
    );

    fcs_advance #(.CW(CW)) u_next (
        .base_i  (st_q.cmp),
        .step_i  (quot_i),
        .extra_i (extra),
        .sum_o   (next_pt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!run_i) begin
            st_d.phase = PH_IDLE;
        end else if (st_q.phase == PH_IDLE) begin
            st_d.phase = PH_RUN;
            st_d.cmp   = arm_pt;
            st_d.acc   = '0;
        end else if (hit) begin
            st_d.evt  = 1'b1;
            st_d.wave = ~st_q.wave;
            st_d.cmp  = next_pt;
            st_d.acc  = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cmp: '0, acc: '0, evt: 1'b0, wave: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign evt_o  = st_q.evt;
    assign wave_o = st_q.wave;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_i,
    input logic          run_i,
    input logic [CW-1:0] quot_i,
    input logic [CW-1:0] cmp_o,
    input logic          evt_o,
    input logic          wave_o
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (cmp_o == '0 && !evt_o && !wave_o); // R1
        end
    end

    AST_ARM_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && !$past(run_i, 2)) |-> (cmp_o == CW'($past(cnt_i) + $past(quot_i)))); // R2

    AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> (!evt_o && $stable(wave_o) && $stable(cmp_o))); // R3

    AST_EVT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(run_i) && ($past(cnt_i) == $past(cmp_o)))); // R4

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o); // R4

    AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (wave_o != $past(wave_o))); // R5

    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_o |-> $stable(wave_o)); // R5

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ((CW'(cmp_o - $past(cmp_o)) == $past(quot_i)) ||
                   (CW'(cmp_o - $past(cmp_o)) == CW'($past(quot_i) + 1'b1)))); // R6
endmodule

bind frac_compare_sched fcs_checker #(.CW(CW)) u_fcs_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_i),
    .run_i  (run_i),
    .quot_i (quot_i),
    .cmp_o  (cmp_o),
    .evt_o  (evt_o),
    .wave_o (wave_o)
);

// File: tb/test_frac_compare_sched.sv
`timescale 1ns/1ps
module test_frac_compare_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_v = '0;
    logic        run = 1'b0;
    logic [15:0] quot = 16'd3, rem = 16'd5, freq = 16'd7;
    logic [15:0] cmp_o;
    logic        evt_o, wave_o;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frac_compare_sched i_frac_compare_sched (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_v), .run_i(run),
        .quot_i(quot), .rem_i(rem), .freq_i(freq),
        .cmp_o(cmp_o), .evt_o(evt_o), .wave_o(wave_o)
    );

    // behavioural reference
    bit m_arm, m_evt, m_wave;
    int m_cmp, m_acc;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_evt = 0; m_wave = 0; m_cmp = 0; m_acc = 0;
        end else begin
            m_evt = 0;
            if (!run) m_arm = 0;
            else if (!m_arm) begin
                m_arm = 1; m_cmp = (int'(cnt_v) + int'(quot)) % 65536; m_acc = 0;
            end else if (int'(cnt_v) == m_cmp) begin
                m_evt = 1; m_wave = !m_wave;
                m_acc = m_acc + int'(rem);
                if (m_acc >= int'(freq)) begin
                    m_acc = m_acc - int'(freq);
                    m_cmp = (m_cmp + int'(quot) + 1) % 65536;
                end else m_cmp = (m_cmp + int'(quot)) % 65536;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cmp_o) == m_cmp, "R6 cmp", int'(cmp_o), m_cmp);
            chk(evt_o == m_evt, "R4 evt", int'(evt_o), int'(m_evt));
            chk(wave_o == m_wave, "R5 wave", int'(wave_o), int'(m_wave));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(0, "watchdog", cycles, 190000);
            finish_up();
        end
    end

    task automatic tick();
        @(negedge clk);
        cnt_v = cnt_v + 16'd1;
    endtask

    task automatic run_events(input int n, output int seen);
        seen = 0;
        while (seen < n) begin
            tick();
            if (evt_o) begin
                seen++;
                tick();
                chk(evt_o == 1'b0, "R4 pulse width", int'(evt_o), 0);
            end
        end
    endtask

    initial begin
        int n;
        logic [15:0] c0, held;
        logic w0;
        repeat (3) tick();
        chk(cmp_o == 16'd0 && !evt_o && !wave_o, "R1 reset",
            int'({cmp_o, evt_o, wave_o}), 0);
        rst_n = 1'b1;

        // idle with run low
        n = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (evt_o) n++;
        end
        chk(n == 0 && !wave_o, "R3 idle", n, 0);

        // arm at 100
        cnt_v = 16'd100; run = 1'b1;
        tick();
        chk(cmp_o == 16'd103, "R2 arm", int'(cmp_o), 103);
        c0 = cmp_o;

        run_events(7, n);
        chk(cmp_o == c0 + 16'd26, "R8 seven-event span", int'(cmp_o), int'(c0 + 16'd26));
        run_events(1, n);   // leaves a shortfall residue of 5

        // stop: nothing moves
        run = 1'b0; held = cmp_o; w0 = wave_o; n = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (evt_o) n++;
        end
        chk(n == 0 && wave_o == w0 && cmp_o == held, "R3 stopped", n, 0);

        // re-arm: first step must be 3 (shortfall cleared)
        cnt_v = 16'd500; run = 1'b1;
        tick();
        chk(cmp_o == 16'd503, "R9 rearm point", int'(cmp_o), 503);
        run_events(1, n);
        chk(cmp_o == 16'd506, "R9 cleared shortfall", int'(cmp_o), 506);

        // wrap and the exact long-term span
        run = 1'b0;
        tick();
        quot = 16'd37; rem = 16'd208; freq = 16'd880;
        tick();
        cnt_v = 16'hFFF0; run = 1'b1;
        tick();
        chk(cmp_o == 16'h0015, "R7 wrap", int'(cmp_o), 16'h15);
        c0 = cmp_o; w0 = wave_o;
        run_events(880, n);
        chk(cmp_o == c0 + 16'h8000, "R8 exact 32768 span", int'(cmp_o), int'(c0 + 16'h8000));
        chk(wave_o == w0, "R5 even toggles", int'(wave_o), int'(w0));

        repeat (3) tick();
        finish_up();
    end
endmodule